// File: doc/BRIEF.md
# DMA Grant Daisy-Chain Requester

This block is the bus-mastership front end of a DMA-capable peripheral on a backplane bus. Bus ownership is granted through a daisy chain. A local client raises a request. The block then drives the active-low DMA request line and watches the grant arriving on its grant-in pin. A device that is not asking for the bus hands the grant on through grant-out. A device that is asking keeps the grant and never lets it travel further down the chain.

After keeping a grant, the block waits until the current bus cycle has fully ended, meaning that both the sync line and the reply line read negated. Only then does it assert select-acknowledge, which is the acceptance of mastership. While it is master, the local client runs its transfers and reports each completed one with a single-cycle done pulse. After a parameterised number of transfers, or as soon as the client withdraws its request, the block negates select-acknowledge and gives the bus back. Transfer generation itself lives in the client; this block only tells the client when it owns the bus.

Top module: `dgc_node`

## Requirements
- R1: While `rst_n` or `init_n` is low at a rising clock edge, the block returns to idle: after that edge `dmr_n`, `sack_n` are 1 and `loc_own` is 0; while either reset is low, `gnt_out_n` stays 1 whatever `gnt_in_n` does.
- R2: `loc_req` high at an edge while idle drives `dmr_n` to 0 after that edge; `sack_n` stays 1.
- R3: While idle, `gnt_out_n` follows `gnt_in_n` combinationally (0 when the grant is present, 1 otherwise).
- R4: While requesting with `loc_req` high, and at all times while waiting for the bus or holding it, `gnt_out_n` stays 1 even with `gnt_in_n` at 0; the grant is kept.
- R5: After a grant is kept, `sack_n` goes to 0 only after an edge at which `sync_n` and `rply_n` are both 1; while either is 0 it stays 1.
- R6: `dmr_n` returns to 1 in the same cycle that `sack_n` goes to 0, and the two are never both 0.
- R7: `loc_own` equals the inverse of `sack_n`; after the XFER_MAX-th `loc_done` pulse during ownership, `sack_n` is 1 after that edge.
- R8: If `loc_req` is low at an edge during ownership, `sack_n` is 1 after that edge.
- R9: If `loc_req` is withdrawn while waiting for a grant, `dmr_n` is 1 after the next edge, and a grant seen in that cycle or later is passed on through `gnt_out_n`.
- R10: `loc_done` pulses outside ownership are ignored: a later tenure still lasts exactly XFER_MAX pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| init_n | input | 1 | Bus initialise, active low, synchronous |
| loc_req | input | 1 | Client asks for bus mastership |
| loc_done | input | 1 | One-cycle pulse per completed client transfer |
| loc_own | output | 1 | Client currently owns the bus |
| gnt_in_n | input | 1 | Grant from the upstream side of the chain, active low |
| gnt_out_n | output | 1 | Grant passed downstream, active low |
| dmr_n | output | 1 | DMA request to the arbiter, active low |
| sack_n | output | 1 | Select-acknowledge (mastership accepted), active low |
| sync_n | input | 1 | Bus sync, active low |
| rply_n | input | 1 | Bus reply, active low |

## Verification
The bench first walks the four combinations of sync and reply after a grant has been kept. A design that accepted the bus with only one of the lines negated would assert select-acknowledge in the middle of another master's cycle. It checks that a grant is withheld from the chain while requesting, owning and during reset. A leak here would hand the bus to two masters at once. It withdraws the request both before and in the same cycle as the grant arrives. A block that kept such a grant would stall the chain. Finally it sends done pulses while idle and checks that the next tenure still lasts exactly XFER_MAX transfers, which would be cut short if the counter counted outside ownership.

// File: rtl/dgc_pkg.sv
// Package: shared state encoding for the daisy-chain requester.
package dgc_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_REQ  = 2'd1,
        ST_WAIT = 2'd2,
        ST_OWN  = 2'd3
    } dgc_state_e;
endpackage

// File: rtl/dgc_fsm.sv
// Module: mastership state machine.
// Walks idle -> requesting -> waiting for bus quiet -> owning -> idle.
// Assumes loc_done is a one-cycle pulse and that bus inputs are synchronised.
module dgc_fsm
    import dgc_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       init_n,
    input  logic       loc_req,
    input  logic       loc_done,
    input  logic       gnt_in_n,
    input  logic       sync_n,
    input  logic       rply_n,
    input  logic       burst_last,
    output dgc_state_e state_q
);
    dgc_state_e state_d;

    // Next-state selection from the current state and bus/client inputs.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (loc_req) state_d = ST_REQ;
            ST_REQ: begin
                if (!loc_req)       state_d = ST_IDLE;
                else if (!gnt_in_n) state_d = ST_WAIT;
            end
            ST_WAIT: if (sync_n && rply_n) state_d = ST_OWN;
            ST_OWN: begin
                if (!loc_req || (loc_done && burst_last)) state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // State register with synchronous local and bus reset.
    always_ff @(posedge clk) begin
        if (!rst_n || !init_n) state_q <= ST_IDLE;
        else                   state_q <= state_d;
    end
endmodule

// File: rtl/dgc_burst_cnt.sv
// Module: transfer counter for one mastership tenure.
// Counts step pulses, held at zero by clear; flags the final transfer.
// Assumes XFER_MAX >= 1.
module dgc_burst_cnt #(
    parameter int XFER_MAX = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic step,
    output logic last
);
    localparam int CNT_W = (XFER_MAX > 1) ? $clog2(XFER_MAX) : 1;
    localparam logic [CNT_W-1:0] LAST_VAL = CNT_W'(XFER_MAX - 1);

    logic [CNT_W-1:0] cnt_q;

    // Count completed transfers while the tenure lasts.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) cnt_q <= '0;
        else if (step)       cnt_q <= cnt_q + 1'b1;
    end

    // Final-transfer flag for the state machine.
    assign last = (cnt_q == LAST_VAL);
endmodule

// File: rtl/dgc_grant_pass.sv
// Module: grant-out gate of the daisy chain.
// Passes grant-in downstream combinationally only when this node does not
// want the bus; blocked entirely during either reset.
module dgc_grant_pass
    import dgc_pkg::*;
(
    input  logic       rst_n,
    input  logic       init_n,
    input  logic       loc_req,
    input  logic       gnt_in_n,
    input  dgc_state_e state_q,
    output logic       gnt_out_n
);
    logic pass_ok;

    // Decide whether this node is transparent to the grant.
    always_comb begin
        pass_ok = rst_n && init_n &&
                  ((state_q == ST_IDLE) || ((state_q == ST_REQ) && !loc_req));
    end

    // Drive the active-low grant onward.
    assign gnt_out_n = !(pass_ok && !gnt_in_n);
endmodule

// File: rtl/dgc_node.sv
// Module: top of the DMA grant daisy-chain requester.
// Requests the bus, keeps or passes the chained grant, accepts mastership
// once sync and reply are both negated, releases after XFER_MAX transfers
// or when the client withdraws. Bus lines are active low.
module dgc_node
    import dgc_pkg::*;
#(
    parameter int XFER_MAX = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic init_n,
    input  logic loc_req,
    input  logic loc_done,
    output logic loc_own,
    input  logic gnt_in_n,
    output logic gnt_out_n,
    output logic dmr_n,
    output logic sack_n,
    input  logic sync_n,
    input  logic rply_n
);
    dgc_state_e state_q;
    logic       burst_last;
    logic       owning;

    dgc_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .init_n     (init_n),
        .loc_req    (loc_req),
        .loc_done   (loc_done),
        .gnt_in_n   (gnt_in_n),
        .sync_n     (sync_n),
        .rply_n     (rply_n),
        .burst_last (burst_last),
        .state_q    (state_q)
    );

    dgc_burst_cnt #(.XFER_MAX(XFER_MAX)) u_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (!owning),
        .step  (owning && loc_done),
        .last  (burst_last)
    );

    dgc_grant_pass u_pass (
        .rst_n     (rst_n),
        .init_n    (init_n),
        .loc_req   (loc_req),
        .gnt_in_n  (gnt_in_n),
        .state_q   (state_q),
        .gnt_out_n (gnt_out_n)
    );

    // Moore decode of bus and client outputs from the state.
    always_comb begin
        owning  = (state_q == ST_OWN);
        loc_own = owning;
        sack_n  = !owning;
        dmr_n   = !((state_q == ST_REQ) || (state_q == ST_WAIT));
    end
endmodule

// File: rtl/dgc_checker.sv
// Module: protocol checker for dgc_node, attached by bind.
// Observes ports only.
module dgc_checker (
    input logic clk,
    input logic rst_n,
    input logic init_n,
    input logic loc_req,
    input logic loc_own,
    input logic gnt_in_n,
    input logic gnt_out_n,
    input logic dmr_n,
    input logic sack_n,
    input logic sync_n,
    input logic rply_n
);
    // R1: bus reset leaves the node idle.
    p_init_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !init_n |=> (dmr_n && sack_n && !loc_own));

    // R1: no grant leaks during bus reset.
    p_init_no_pass_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !init_n |-> gnt_out_n);

    // R3: idle node is transparent to the grant.
    p_idle_pass_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (init_n && dmr_n && sack_n && !loc_own && !gnt_in_n) |-> !gnt_out_n);

    // R4: a live request keeps the grant.
    p_req_keeps_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!dmr_n && loc_req) |-> gnt_out_n);

    // R4: an owner never passes the grant.
    p_own_keeps_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !sack_n |-> gnt_out_n);

    // R5: acceptance only after sync and reply were both negated.
    p_accept_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sack_n) |-> ($past(sync_n) && $past(rply_n)));

    // R6: request and acknowledge never active together.
    p_req_ack_excl_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (dmr_n || sack_n));

    // R7: client ownership mirrors select-acknowledge.
    p_own_mirror_r7: assert property (@(posedge clk) disable iff (!rst_n)
        loc_own == !sack_n);

    // R8: withdrawn request during ownership releases the bus.
    p_withdraw_release_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!sack_n && !loc_req) |=> sack_n);
endmodule

bind dgc_node dgc_checker u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .init_n    (init_n),
    .loc_req   (loc_req),
    .loc_own   (loc_own),
    .gnt_in_n  (gnt_in_n),
    .gnt_out_n (gnt_out_n),
    .dmr_n     (dmr_n),
    .sack_n    (sack_n),
    .sync_n    (sync_n),
    .rply_n    (rply_n)
);

// File: tb/dgc_node_tb.sv
// Bench: self-checking test of dgc_node with a vector table and directed tests.
module dgc_node_tb;
    localparam int N = 4;

    // One row of the bus-quiet table: sync_n, rply_n, expected sack_n.
    typedef struct packed {
        logic sync_n;
        logic rply_n;
        logic exp_sack_n;
    } vec_t;

    localparam vec_t VECS [5] = '{
        '{1'b0, 1'b0, 1'b1},
        '{1'b0, 1'b1, 1'b1},
        '{1'b1, 1'b0, 1'b1},
        '{1'b0, 1'b0, 1'b1},
        '{1'b1, 1'b1, 1'b0}
    };

    logic clk = 1'b0;
    logic rst_n, init_n, loc_req, loc_done, gnt_in_n, sync_n, rply_n;
    logic loc_own, gnt_out_n, dmr_n, sack_n;
    int   n_chk = 0;
    int   n_fail = 0;
    bit   done = 1'b0;

    always #4 clk = ~clk;

    dgc_node #(.XFER_MAX(N)) u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .init_n    (init_n),
        .loc_req   (loc_req),
        .loc_done  (loc_done),
        .loc_own   (loc_own),
        .gnt_in_n  (gnt_in_n),
        .gnt_out_n (gnt_out_n),
        .dmr_n     (dmr_n),
        .sack_n    (sack_n),
        .sync_n    (sync_n),
        .rply_n    (rply_n)
    );

    // Advance one clock; return at the falling edge.
    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic check(input string tag, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %b expected %b", tag, act, exp);
        end
    endtask

    // Take the bus from idle with a quiet bus; ends owning.
    task automatic acquire();
        loc_req = 1'b1;
        tick();
        gnt_in_n = 1'b0;
        sync_n = 1'b1;
        rply_n = 1'b1;
        tick();
        tick();
        gnt_in_n = 1'b1;
        #1;
    endtask

    task automatic pulse_done();
        loc_done = 1'b1;
        tick();
        loc_done = 1'b0;
    endtask

    initial begin
        rst_n = 1'b0; init_n = 1'b1; loc_req = 1'b0; loc_done = 1'b0;
        gnt_in_n = 1'b0; sync_n = 1'b0; rply_n = 1'b0;
        @(negedge clk);
        tick();
        tick();
        check("R1 reset dmr_n", dmr_n, 1'b1);
        check("R1 reset sack_n", sack_n, 1'b1);
        check("R1 reset loc_own", loc_own, 1'b0);
        check("R1 reset blocks grant", gnt_out_n, 1'b1);
        gnt_in_n = 1'b1;
        rst_n = 1'b1;
        tick();

        // R3: idle pass-through
        gnt_in_n = 1'b0; #1;
        check("R3 idle passes grant", gnt_out_n, 1'b0);
        gnt_in_n = 1'b1; #1;
        check("R3 idle grant removed", gnt_out_n, 1'b1);

        // R2: request
        loc_req = 1'b1;
        tick();
        check("R2 dmr_n asserted", dmr_n, 1'b0);
        check("R2 sack_n idle", sack_n, 1'b1);

        // R4: keep grant while requesting
        gnt_in_n = 1'b0; #1;
        check("R4 requesting keeps grant", gnt_out_n, 1'b1);

        // R5: walk the bus-quiet vector table
        foreach (VECS[i]) begin
            sync_n = VECS[i].sync_n;
            rply_n = VECS[i].rply_n;
            tick();
            check("R5 sack_n vs sync/reply", sack_n, VECS[i].exp_sack_n);
            check("R4 no pass while waiting/owning", gnt_out_n, 1'b1);
        end
        check("R6 dmr_n dropped with sack", dmr_n, 1'b1);
        check("R7 loc_own while owning", loc_own, 1'b1);
        gnt_in_n = 1'b1;

        // R7: burst length
        for (int k = 0; k < N - 1; k++) begin
            pulse_done();
            check("R7 still owning mid burst", sack_n, 1'b0);
        end
        pulse_done();
        check("R7 released after last transfer", sack_n, 1'b1);
        check("R7 loc_own cleared", loc_own, 1'b0);
        loc_req = 1'b0;
        tick();

        // R10: stray done pulses while idle
        pulse_done();
        pulse_done();
        acquire();
        check("R10 owning after reacquire", sack_n, 1'b0);
        for (int k = 0; k < N - 1; k++) pulse_done();
        check("R10 idle pulses ignored, still owning", sack_n, 1'b0);
        pulse_done();
        check("R10 release on Nth pulse", sack_n, 1'b1);
        loc_req = 1'b0;
        tick();

        // R8: withdrawal during ownership
        acquire();
        check("R8 owning before withdraw", sack_n, 1'b0);
        loc_req = 1'b0;
        tick();
        check("R8 withdraw releases", sack_n, 1'b1);

        // R9: withdraw before grant, then grant arrives
        loc_req = 1'b1;
        tick();
        check("R9 requesting", dmr_n, 1'b0);
        loc_req = 1'b0;
        tick();
        check("R9 request dropped", dmr_n, 1'b1);
        gnt_in_n = 1'b0; #1;
        check("R9 late grant passed", gnt_out_n, 1'b0);
        gnt_in_n = 1'b1;
        tick();

        // R9: withdraw in the same cycle the grant arrives
        loc_req = 1'b1;
        tick();
        loc_req = 1'b0;
        gnt_in_n = 1'b0; #1;
        check("R9 simultaneous grant passed", gnt_out_n, 1'b0);
        tick();
        check("R9 grant not kept sack_n", sack_n, 1'b1);
        check("R9 grant not kept dmr_n", dmr_n, 1'b1);
        gnt_in_n = 1'b1;
        tick();

        // R1: bus initialise during ownership
        acquire();
        init_n = 1'b0;
        tick();
        check("R1 init clears sack_n", sack_n, 1'b1);
        check("R1 init clears loc_own", loc_own, 1'b0);
        check("R1 init clears dmr_n", dmr_n, 1'b1);
        gnt_in_n = 1'b0; #1;
        check("R1 init blocks grant", gnt_out_n, 1'b1);
        gnt_in_n = 1'b1;
        init_n = 1'b1;
        loc_req = 1'b0;
        tick();

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule